// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers link-health events from a receive front end into one 8-bit status word that software polls or reacts to through a single interrupt line. It watches the CDR lock level and the carrier-detect levels of two inputs. It turns each level edge into a pair of sticky flags, one for the level being gained and one for it being lost. A single-cycle eye-threshold pulse sets a further flag. The top bit of the status word is not sticky. It shows the present carrier-detect level of whichever input is selected.

Software reaches the block through a small strobe-based register port with a control register, the status register and an enable register. Reading the status register returns the word and clears every sticky flag. An event that lands in the same cycle as that read is kept for the next read. The enables decide only which sticky flags pull the active-low interrupt output. The flags themselves latch whatever the enables are. A self-clearing bit in the control register puts the flags and enables back to their reset values.

Top module: `irq_status_ctrl`

## Requirements
- R1: After the synchronous reset, the control, status and enable registers all read 8'h00 while all level inputs are low, and `irq_n` is 1.
- R2: Status bit 7 shows the synchronized carrier-detect level of the input chosen by `sel_in` (0 selects input 0, 1 selects input 1). A status read does not clear it.
- R3: A rising edge of `lock_lvl` sets status bit 6. A falling edge sets status bit 2.
- R4: A rising carrier-detect edge sets bit 5 for input 1 and bit 4 for input 0. A falling edge sets bit 1 for input 1 and bit 0 for input 0. Both inputs are watched regardless of `sel_in`.
- R5: A one-cycle pulse on `eye_evt` sets status bit 3.
- R6: A read of the status register (address 1) returns the word and clears bits 6:0. A following read with no new events returns only bit 7.
- R7: An event arriving in the same cycle as a status read is absent from that read's data and present in the next read.
- R8: Sticky flags latch even when their enables are 0.
- R9: The enable register (address 2) holds one enable per flag in bits 6:0, and bit 7 reads 0. `irq_n` is 0 exactly while some flag in bits 6:0 and its enable are both 1.
- R10: Writing 1 to bit 0 of the control register (address 0) clears all sticky flags and enables. The control bit then reads back 0 without any further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_lvl | input | 1 | CDR lock level (asynchronous) |
| cd_lvl | input | 2 | Carrier-detect levels of inputs 1 and 0 (asynchronous) |
| eye_evt | input | 1 | One-cycle eye-threshold pulse (clock domain) |
| sel_in | input | 1 | Index of the selected input for status bit 7 |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data appears on reg_rdata after the next edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The hardest situation to reach is an event that coincides exactly with the clearing read, because level inputs pass through a synchronizer and an edge detector before they reach the flags. The bench drives the eye-threshold pulse in the very cycle of the read strobe, since that pulse sets its flag without added latency. It then checks that the read data omits the flag and that the next read shows it. The lock-loss and carrier-loss flags each need the level raised and the resulting assert flag cleared first, so the bench builds every single-flag state through that preparation step. Only then does it sweep all 128 enable values against it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int FLAG_W    = 7;
  localparam int N_CD      = 2;
  localparam int SYNC_LEN  = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_EN   = 2'd2;

  // flag positions inside the status word
  localparam int B_LOCK_UP  = 6;
  localparam int B_CD1_UP   = 5;
  localparam int B_CD0_UP   = 4;
  localparam int B_EYE      = 3;
  localparam int B_LOCK_DN  = 2;
  localparam int B_CD1_DN   = 1;
  localparam int B_CD0_DN   = 0;

  typedef logic [FLAG_W-1:0] flag_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output flag_t             en_q,
  output flag_t             en_d,
  output logic              srst_q
);
  logic wr_ctrl, wr_en;
  logic unused_wbits;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_en   = wr && (addr == ADR_EN);
  assign unused_wbits = wdata[DATA_W-1];

  always_comb begin
    if (srst_q)     en_d = '0;
    else if (wr_en) en_d = wdata[FLAG_W-1:0];
    else            en_d = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      srst_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      srst_q <= !srst_q && wr_ctrl && wdata[0];
    end
  end

  assert_en_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (en_q == '0));
  assert_srst_selfclear_R10: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> !srst_q);
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  srst,
  input  logic  clr,
  input  flag_t evt,
  output flag_t flags_q,
  output flag_t flags_d
);
  always_comb begin
    if (srst) flags_d = '0;
    else      flags_d = (flags_q & ~{FLAG_W{clr}}) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && (evt == '0) && !srst) |=> (flags_q == '0));
  assert_event_kept_R7: assert property (@(posedge clk) disable iff (rst)
    ((evt != '0) && !srst) |=> ((flags_q & $past(evt)) == $past(evt)));
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !srst) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    srst |=> (flags_q == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_lvl,
  input  logic [N_CD-1:0]   cd_lvl,
  input  logic              eye_evt,
  input  logic              sel_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  localparam int LW = N_CD + 1;

  logic [LW-1:0] lvl_s, lvl_rise, lvl_fall;
  flag_t evt, flags_q, flags_d, en_q, en_d;
  logic  srst_q, live_cd, rd_stat;

  // lvl_s[0] lock, lvl_s[1] input 0, lvl_s[2] input 1
  irq_sync #(.W(LW), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d({cd_lvl, lock_lvl}), .q(lvl_s));

  irq_edge #(.W(LW)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_s), .rise(lvl_rise), .fall(lvl_fall));

  always_comb begin
    evt            = '0;
    evt[B_LOCK_UP] = lvl_rise[0];
    evt[B_LOCK_DN] = lvl_fall[0];
    evt[B_CD0_UP]  = lvl_rise[1];
    evt[B_CD0_DN]  = lvl_fall[1];
    evt[B_CD1_UP]  = lvl_rise[2];
    evt[B_CD1_DN]  = lvl_fall[2];
    evt[B_EYE]     = eye_evt;
  end

  assign rd_stat = reg_rd && (reg_addr == ADR_STAT);
  assign live_cd = sel_in ? lvl_s[2] : lvl_s[1];

  irq_regfile u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .en_d(en_d), .srst_q(srst_q));

  irq_sticky u_sticky (
    .clk(clk), .rst(rst), .srst(srst_q), .clr(rd_stat), .evt(evt),
    .flags_q(flags_q), .flags_d(flags_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      irq_n <= ~|(flags_d & en_d);
      if (reg_rd) begin
        case (reg_addr)
          ADR_CTRL: reg_rdata <= {{(DATA_W-1){1'b0}}, srst_q};
          ADR_STAT: reg_rdata <= {live_cd, flags_q};
          ADR_EN:   reg_rdata <= {1'b0, en_q};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_irq_matches_R9: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(flags_q & en_q)));
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_lvl = 1'b0;
  logic [1:0] cd_lvl = 2'b00;
  logic       eye_evt = 1'b0;
  logic       sel_in = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [6:0] exp_flags = '0;

  always #(PERIOD/2) clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk(clk), .rst(rst), .lock_lvl(lock_lvl), .cd_lvl(cd_lvl), .eye_evt(eye_evt),
    .sel_in(sel_in), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic stat_check(input string req);
    logic [7:0] d;
    reg_read(2'd1, d);
    check(req, d, {cd_lvl[sel_in], exp_flags});
    exp_flags = '0;
  endtask

  task automatic set_lock(input logic v);
    if (v !== lock_lvl) exp_flags |= v ? 7'h40 : 7'h04;
    lock_lvl = v;
    tick(4);
  endtask

  task automatic set_cd(input int i, input logic v);
    if (v !== cd_lvl[i]) exp_flags |= v ? (7'h10 << i) : (7'h01 << i);
    cd_lvl[i] = v;
    tick(4);
  endtask

  task automatic pulse_eye();
    eye_evt = 1'b1;
    @(negedge clk);
    eye_evt = 1'b0;
    exp_flags |= 7'h08;
  endtask

  task automatic make_only(input int k);
    logic [7:0] d;
    case (k)
      6: set_lock(1'b0);
      2: set_lock(1'b1);
      5, 1: set_cd(1, (k == 1));
      4, 0: set_cd(0, (k == 0));
      default: ;
    endcase
    reg_read(2'd1, d);
    exp_flags = '0;
    case (k)
      6: set_lock(1'b1);
      2: set_lock(1'b0);
      5: set_cd(1, 1'b1);
      1: set_cd(1, 1'b0);
      4: set_cd(0, 1'b1);
      0: set_cd(0, 1'b0);
      default: pulse_eye();
    endcase
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    reg_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    reg_read(2'd1, d); check("R1 status", d, 8'h00);
    reg_read(2'd2, d); check("R1 enable", d, 8'h00);

    // R3 / R4 edge sweep, two rounds, enables off (R8)
    for (int r = 0; r < 2; r++) begin
      set_lock(1'b1); stat_check("R3 lock up R8");
      set_cd(0, 1'b1); stat_check("R4 cd0 up");
      set_cd(1, 1'b1); stat_check("R4 cd1 up");
      set_lock(1'b0); stat_check("R3 lock down");
      set_cd(0, 1'b0); stat_check("R4 cd0 down");
      set_cd(1, 1'b0); stat_check("R4 cd1 down");
    end
    // combined edges in one window
    lock_lvl = 1'b1; cd_lvl = 2'b11; exp_flags = 7'h70; tick(4);
    stat_check("R4 combined up");
    stat_check("R6 second read clear");
    lock_lvl = 1'b0; cd_lvl = 2'b00; exp_flags = 7'h07; tick(4);
    stat_check("R4 combined down");

    // R5 eye pulse
    pulse_eye(); tick(1); stat_check("R5 eye flag");

    // R2 live bit over select and levels
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        sel_in = s[0];
        set_cd(0, c[0]); set_cd(1, c[1]);
        stat_check("R2 live bit first read");
        stat_check("R2 live bit after clear R6");
      end
    end
    sel_in = 1'b0; set_cd(0, 1'b0); set_cd(1, 1'b0);
    stat_check("R6 clean");

    // R7 event coinciding with status read
    eye_evt = 1'b1; reg_addr = 2'd1; reg_rd = 1'b1;
    @(negedge clk);
    eye_evt = 1'b0; reg_rd = 1'b0;
    check("R7 read excludes same-cycle event", reg_rdata, 8'h00);
    exp_flags = 7'h08;
    stat_check("R7 event kept for next read");

    // R9 enable sweep against each single flag
    for (int k = 0; k < 7; k++) begin
      make_only(k);
      for (int e = 0; e < 128; e++) begin
        reg_write(2'd2, 8'(e) | 8'h80);
        check("R9 irq_n", {7'b0, irq_n}, {7'b0, ~e[k]});
        if (e % 16 == 5) begin
          reg_read(2'd2, d); check("R9 enable readback", d, 8'(e));
        end
      end
      reg_write(2'd2, 8'h00);
      check("R8 flag kept with enables off", {7'b0, irq_n}, 8'h01);
      exp_flags = 7'(1 << k);
      stat_check("R8 single flag latched");
    end

    // R10 soft reset
    reg_write(2'd2, 8'h7F);
    pulse_eye(); set_lock(1'b1);
    tick(1);
    check("R10 irq before soft reset", {7'b0, irq_n}, 8'h00);
    reg_write(2'd0, 8'h01);
    tick(2);
    check("R10 irq released", {7'b0, irq_n}, 8'h01);
    reg_read(2'd0, d); check("R10 ctrl self-clear", d, 8'h00);
    reg_read(2'd2, d); check("R10 enables cleared", d, 8'h00);
    exp_flags = '0;
    stat_check("R10 flags cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule